// File: doc/BRIEF.md
# Power-up reset time-out sequencer

This block keeps the processor core in reset after a reset event and lets it go only once a fixed chain of delays has run out. A power-on pulse or a brown-out event starts the chain. A power-up timer runs first, then an oscillator start-up timer. Each stage may be skipped, depending on the reset cause and on two configuration inputs. A wake from sleep runs only the oscillator stage.

The chain is timed from the power-on pulse and not from the external reset pin. The pin is resynchronised and can force reset on its own at any moment. If the pin is held low until the chain has finished, the core starts two clocks after the pin returns high. This lets several devices be started together.

The controller is a four-state machine:
- `ST_HOLD`: waiting for the power-on or brown-out condition to clear.
- `ST_PWRT`: the power-up timer is running.
- `ST_OST`: the oscillator start-up timer is running.
- `ST_RUN`: the chain is finished.

Its transitions are:
- HOLD→PWRT when the timer is enabled.
- HOLD→OST when the timer is disabled and the crystal is selected.
- HOLD→RUN when neither applies.
- PWRT→OST or PWRT→RUN when the power-up timer expires, depending on the crystal select.
- OST→RUN when the start-up timer expires.
- RUN→OST on a wake in crystal mode.
- Any state→HOLD on a brown-out.
- Any state→HOLD, asynchronously, on the power-on pulse.

Top module: `rst_timeout_seq`

## Requirements
- R1: While `por_pulse` is 1, `core_rst` is 1. The sequence starts at the first rising clock edge after `por_pulse` falls (edge 1).
- R2: With `cfg_pwrt_en`=1 the power-up stage lasts exactly `PWRT_LEN` clocks. With `cfg_pwrt_en`=0 it adds no clocks.
- R3: The start-up stage follows the power-up stage and lasts `OST_LEN` clocks when `cfg_osc_xtal`=1 (crystal). When `cfg_osc_xtal`=0 (external clock or internal oscillator) it is skipped.
- R4: After a power-on release with the pin high, `core_rst` first reads 0 after edge max(1 + PWRT_LEN·en + OST_LEN·xtal, 2). The minimum of 2 comes from the pin synchroniser, which is cleared by power-on.
- R5: `bod_evt`=1 at an edge forces reset and returns the sequence to its first stage. After `bod_evt` falls, `core_rst` first reads 0 after edge 1 + PWRT_LEN·en + OST_LEN·xtal.
- R6: `wake_evt` seen at an edge while running never starts the power-up stage. In crystal mode it holds reset, and `core_rst` first reads 0 after edge 1 + OST_LEN. Otherwise reset is not asserted. A wake during a time-out has no effect on the release edge.
- R7: `ext_rst_n` passes a two-flop synchroniser. A low level asserts `core_rst` after the second edge, and a return high releases it after the second edge.
- R8: If `ext_rst_n` stays low beyond the time-outs, `core_rst` falls after the second edge following the pin's rise.
- R9: A brown-out during a running time-out restarts the chain, so the release edge is counted again from the end of that brown-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_pulse | input | 1 | Power-on reset pulse, active high, asynchronous |
| bod_evt | input | 1 | Brown-out event, active high, synchronous |
| wake_evt | input | 1 | Wake-from-sleep event, active high |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| cfg_pwrt_en | input | 1 | 1 enables the power-up timer |
| cfg_osc_xtal | input | 1 | 1 = crystal (start-up timer used), 0 = external clock / internal oscillator |
| core_rst | output | 1 | Internal reset to the core, active high |

## Verification
Each result has a fixed edge count from its stimulus:
- A power-on release is due 1 + PWRT_LEN·en + OST_LEN·xtal edges later, but never before edge 2.
- A brown-out release follows the same sum, counted from the end of the brown-out.
- A wake release is due 1 + OST_LEN edges later.
- A pin change takes effect on the second edge.

The bench drives every input just after a falling edge and samples `core_rst` on the next falling edge. It counts rising edges up to the first sample that reads 0 and compares that count with the sum worked out from the requirement. For pin changes it also checks the sample after the first edge, to show that the change is not seen early.

// File: rtl/rts_pkg.sv
package rts_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_PWRT = 2'd1,
        ST_OST  = 2'd2,
        ST_RUN  = 2'd3
    } rts_state_e;

endpackage

// File: rtl/rts_sync.sv
module rts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) sh[0] <= 1'b0;
        else      sh[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or posedge arst) begin
            if (arst) sh[i] <= 1'b0;
            else      sh[i] <= sh[i-1];
        end
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/rts_count.sv
module rts_count #(
    parameter int LEN = 1024
) (
    input  logic clk,
    input  logic arst,
    input  logic run,
    output logic expired
);
    localparam int W = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [W-1:0] LAST = W'(LEN - 1);

    logic [W-1:0] cnt;

    // Expiry is flagged in the last counted cycle, so a stage of LEN
    // clocks ends on its LEN-th edge.
    assign expired = run && (cnt == LAST);

    always_ff @(posedge clk or posedge arst) begin
        if (arst)                 cnt <= '0;
        else if (!run || expired) cnt <= '0;
        else                      cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rts_fsm.sv
module rts_fsm
    import rts_pkg::*;
(
    input  logic       clk,
    input  logic       arst,
    input  logic       bod_evt,
    input  logic       wake_evt,
    input  logic       pwrt_en,
    input  logic       osc_xtal,
    input  logic       pwrt_done,
    input  logic       ost_done,
    output rts_state_e state,
    output logic       pwrt_run,
    output logic       ost_run,
    output logic       seq_done
);
    rts_state_e nxt;

    // Stage that follows the power-up stage, or replaces it when skipped.
    function automatic rts_state_e after_pwrt(input logic xtal);
        return xtal ? ST_OST : ST_RUN;
    endfunction

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HOLD: nxt = pwrt_en ? ST_PWRT : after_pwrt(osc_xtal);
            ST_PWRT: if (pwrt_done) nxt = after_pwrt(osc_xtal);
            ST_OST:  if (ost_done) nxt = ST_RUN;
            ST_RUN:  if (wake_evt && osc_xtal) nxt = ST_OST;
            default: nxt = ST_HOLD;
        endcase
        if (bod_evt) nxt = ST_HOLD;
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) state <= ST_HOLD;
        else      state <= nxt;
    end

    always_comb begin
        pwrt_run = (state == ST_PWRT);
        ost_run  = (state == ST_OST);
        seq_done = (state == ST_RUN);
    end
endmodule

// File: rtl/rst_timeout_seq.sv
module rst_timeout_seq
    import rts_pkg::*;
#(
    parameter int PWRT_LEN    = 2048,
    parameter int OST_LEN     = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_pulse,
    input  logic bod_evt,
    input  logic wake_evt,
    input  logic ext_rst_n,
    input  logic cfg_pwrt_en,
    input  logic cfg_osc_xtal,
    output logic core_rst
);
    rts_state_e state_q;
    logic pin_ok, pwrt_run, ost_run, pwrt_done, ost_done, seq_done;

    rts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .arst(por_pulse), .d(ext_rst_n), .q(pin_ok)
    );

    rts_count #(.LEN(PWRT_LEN)) u_pwrt (
        .clk(clk), .arst(por_pulse), .run(pwrt_run), .expired(pwrt_done)
    );

    rts_count #(.LEN(OST_LEN)) u_ost (
        .clk(clk), .arst(por_pulse), .run(ost_run), .expired(ost_done)
    );

    rts_fsm u_fsm (
        .clk(clk), .arst(por_pulse), .bod_evt(bod_evt), .wake_evt(wake_evt),
        .pwrt_en(cfg_pwrt_en), .osc_xtal(cfg_osc_xtal),
        .pwrt_done(pwrt_done), .ost_done(ost_done),
        .state(state_q), .pwrt_run(pwrt_run), .ost_run(ost_run),
        .seq_done(seq_done)
    );

    assign core_rst = !seq_done || !pin_ok;
endmodule

// File: rtl/rts_checker.sv
module rts_checker
    import rts_pkg::*;
(
    input logic       clk,
    input logic       por_pulse,
    input logic       bod_evt,
    input logic       wake_evt,
    input logic       ext_rst_n,
    input logic       cfg_pwrt_en,
    input logic       cfg_osc_xtal,
    input logic       core_rst,
    input rts_state_e state
);
    p_bod_to_hold_r5: assert property (@(posedge clk) disable iff (por_pulse)
        bod_evt |=> state == ST_HOLD);

    p_pwrt_skipped_r2: assert property (@(posedge clk) disable iff (por_pulse)
        (!cfg_pwrt_en && state != ST_PWRT) |=> state != ST_PWRT);

    p_ost_skipped_r3: assert property (@(posedge clk) disable iff (por_pulse)
        (!cfg_osc_xtal && state != ST_OST) |=> state != ST_OST);

    p_ost_not_back_r3: assert property (@(posedge clk) disable iff (por_pulse)
        state == ST_OST |=> state != ST_PWRT);

    p_wake_no_pwrt_r6: assert property (@(posedge clk) disable iff (por_pulse)
        (wake_evt && !bod_evt && state == ST_RUN) |=> state != ST_PWRT);

    p_pin_forces_rst_r7: assert property (@(posedge clk) disable iff (por_pulse)
        (!ext_rst_n ##1 !ext_rst_n) |=> core_rst);

    p_release_in_run_r4: assert property (@(posedge clk) disable iff (por_pulse)
        $fell(core_rst) |-> state == ST_RUN);

    p_por_holds_r1: assert property (@(posedge clk)
        por_pulse |-> core_rst);
endmodule

bind rst_timeout_seq rts_checker u_chk (
    .clk(clk), .por_pulse(por_pulse), .bod_evt(bod_evt), .wake_evt(wake_evt),
    .ext_rst_n(ext_rst_n), .cfg_pwrt_en(cfg_pwrt_en),
    .cfg_osc_xtal(cfg_osc_xtal), .core_rst(core_rst), .state(state_q)
);

// File: tb/sim_rst_timeout_seq.sv
module sim_rst_timeout_seq;
    localparam int CLK_PERIOD = 10;
    localparam int P = 5;
    localparam int O = 7;

    logic clk = 1'b0;
    logic por_pulse = 1'b1, bod_evt = 1'b0, wake_evt = 1'b0, ext_rst_n = 1'b1;
    logic cfg_pwrt_en = 1'b0, cfg_osc_xtal = 1'b0;
    logic core_rst;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_timeout_seq #(.PWRT_LEN(P), .OST_LEN(O)) u0 (
        .clk(clk), .por_pulse(por_pulse), .bod_evt(bod_evt), .wake_evt(wake_evt),
        .ext_rst_n(ext_rst_n), .cfg_pwrt_en(cfg_pwrt_en),
        .cfg_osc_xtal(cfg_osc_xtal), .core_rst(core_rst)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Counts edges until core_rst is first seen low at a falling edge.
    task automatic edges_to_release(input int start, output int k);
        k = start;
        while (core_rst && k < 5000) begin
            step();
            k++;
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        int k, exp_n;
        @(negedge clk);
        check(core_rst == 1'b1, "R1 reset state", core_rst, 1);
        for (int cfg = 0; cfg < 4; cfg++) begin
            // Power-on with the pin high (R1, R2, R3, R4)
            por_pulse = 1'b1;
            cfg_pwrt_en = cfg[0];
            cfg_osc_xtal = cfg[1];
            ext_rst_n = 1'b1;
            step(); step(); step();
            check(core_rst == 1'b1, "R1 held during por", core_rst, 1);
            exp_n = 1 + P * cfg[0] + O * cfg[1];
            por_pulse = 1'b0;
            edges_to_release(0, k);
            check(k == ((exp_n < 2) ? 2 : exp_n), "R4 R2 R3 por release edge", k,
                  (exp_n < 2) ? 2 : exp_n);

            // Brown-out (R5)
            bod_evt = 1'b1;
            step();
            check(core_rst == 1'b1, "R5 bod asserts", core_rst, 1);
            bod_evt = 1'b0;
            edges_to_release(0, k);
            check(k == exp_n, "R5 bod release edge", k, exp_n);

            // Wake from run (R6)
            wake_evt = 1'b1;
            step();
            wake_evt = 1'b0;
            edges_to_release(1, k);
            check(k == (cfg[1] ? 1 + O : 1), "R6 wake release edge", k, cfg[1] ? 1 + O : 1);

            if (cfg[0]) begin
                // Wake during a time-out is ignored (R6)
                bod_evt = 1'b1;
                step();
                bod_evt = 1'b0;
                step();
                wake_evt = 1'b1;
                step();
                wake_evt = 1'b0;
                edges_to_release(2, k);
                check(k == exp_n, "R6 wake ignored in time-out", k, exp_n);

                // Brown-out during power-up stage restarts it (R9)
                bod_evt = 1'b1;
                step();
                bod_evt = 1'b0;
                step(); step(); step();
                check(core_rst == 1'b1, "R9 still in time-out", core_rst, 1);
                bod_evt = 1'b1;
                step();
                bod_evt = 1'b0;
                edges_to_release(0, k);
                check(k == exp_n, "R9 restart release edge", k, exp_n);
            end

            // Pin low while running (R7)
            ext_rst_n = 1'b0;
            step();
            check(core_rst == 1'b0, "R7 pin not seen after 1 edge", core_rst, 0);
            step();
            check(core_rst == 1'b1, "R7 pin low asserts", core_rst, 1);
            ext_rst_n = 1'b1;
            step();
            check(core_rst == 1'b1, "R7 pin high not seen after 1 edge", core_rst, 1);
            step();
            check(core_rst == 1'b0, "R7 pin high releases", core_rst, 0);

            // Pin held low through the whole chain (R8)
            por_pulse = 1'b1;
            ext_rst_n = 1'b0;
            step();
            por_pulse = 1'b0;
            for (int i = 0; i < exp_n + 5; i++) step();
            check(core_rst == 1'b1, "R8 held by pin", core_rst, 1);
            ext_rst_n = 1'b1;
            step();
            check(core_rst == 1'b1, "R8 one edge after rise", core_rst, 1);
            step();
            check(core_rst == 1'b0, "R8 release two edges after rise", core_rst, 0);
        end
        summary();
    end
endmodule